// File: doc/BRIEF.md
# Reference divider with test-output selector

This block divides the synthesizer reference clock by a programmable ratio of 3, 4 or 6. With a 10.368 MHz, 13.824 MHz or 20.736 MHz reference, the matching ratio gives a 3.456 MHz comparison rate. The block runs in the reference clock domain. Its divider output is a one-cycle pulse that marks each comparison instant for the phase detector.

The block also drives a single monitor pin. A 3-bit test code sets what this pin carries: the lock flag from the lock detector, the reference pulses halved, the feedback-divider pulses halved, the reference pulses divided by 512, or the raw reference pulses. The top bit of the same code decides whether the charge pump is enabled or left at high impedance. The lock flag comes in from outside the block. The feedback-divider output arrives as a one-cycle pulse that is already synchronous to the reference clock.

A new ratio code is picked up only at a terminal count. The period that is running when the code changes therefore always completes at its old length.

Top module: `refdiv_mon`

## Requirements
- R1: The ratio code ratio_sel_i sets the spacing between consecutive ref_pulse_o pulses: 2'b00 gives 3 clocks, 2'b01 gives 4, 2'b10 gives 6 and 2'b11 gives 3. Each pulse is one clock wide.
- R2: The ratio code is sampled only in a cycle in which ref_pulse_o is high. The interval that follows that pulse uses the sampled code, so a change in the middle of a period leaves the current interval at its old length.
- R3: When test_sel_i[1:0] is 2'b00 (codes 000 and 100), mon_o equals lock_i in the same cycle.
- R4: When test_sel_i[1:0] is 2'b01, mon_o is a square wave that toggles on the clock edge that ends each ref_pulse_o cycle and holds its value otherwise.
- R5: When test_sel_i[1:0] is 2'b10, mon_o toggles on the clock edge that ends each cycle with fb_pulse_i high and holds its value otherwise.
- R6: When test_sel_i is 3'b011, mon_o is bit 8 of a count of ref_pulse_o cycles. It changes only on the edge after a pulse and has a period of 512 pulses.
- R7: When test_sel_i is 3'b111, mon_o equals ref_pulse_o in the same cycle.
- R8: cp_en_o is 1 when test_sel_i[2] is 0 and 0 when test_sel_i[2] is 1.
- R9: In the first cycle after reset is released, ref_pulse_o is high, and the halving and 512 stages both read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_sel_i | input | 2 | Reference ratio code |
| test_sel_i | input | 3 | Monitor source and charge-pump control code |
| lock_i | input | 1 | Lock flag from the lock detector |
| fb_pulse_i | input | 1 | One-cycle pulse from the feedback divider |
| ref_pulse_o | output | 1 | One-cycle pulse at the comparison rate |
| mon_o | output | 1 | Monitor pin |
| cp_en_o | output | 1 | Charge pump enable; 0 means high impedance |

## Verification
The bound checker checks on every cycle:
- the spacing between pulses, against the ratio code captured at the previous pulse;
- that the monitor follows the lock flag or the raw pulse when those sources are selected;
- that the halving and 512 stages change only on the edge after a qualifying pulse;
- the charge-pump enable.

Only the bench scenarios can show the rest: the actual 512-pulse period and the phase it has after reset, that a mid-period ratio change produces no runt, the toggle phase of each halved clock, and the reset state.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int CNT_W = 3;

  // ratio code to division factor; unused code falls back to 3
  function automatic logic [CNT_W-1:0] ratio_of(input logic [1:0] code);
    case (code)
      2'b01:   ratio_of = CNT_W'(4);
      2'b10:   ratio_of = CNT_W'(6);
      default: ratio_of = CNT_W'(3);
    endcase
  endfunction
endpackage

// File: rtl/refdiv_counter.sv
module refdiv_counter
  import refdiv_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] ratio_sel_i,
  output logic       tc_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tc_o = (cnt_q == '0);

  // ratio sampled only at terminal count: no runt periods
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (tc_o) cnt_q <= ratio_of(ratio_sel_i) - CNT_W'(1);
    else           cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/refdiv_tap.sv
module refdiv_tap #(
  parameter int W = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic q_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + W'(1);
  end

  assign q_o = cnt_q[W-1];
endmodule

// File: rtl/refdiv_mon.sv
module refdiv_mon #(
  parameter int SLOW_W = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] ratio_sel_i,
  input  logic [2:0] test_sel_i,
  input  logic       lock_i,
  input  logic       fb_pulse_i,
  output logic       ref_pulse_o,
  output logic       mon_o,
  output logic       cp_en_o
);
  localparam int N_HALF = 2;

  logic              ref_tc;
  logic [N_HALF-1:0] half_en;
  logic [N_HALF-1:0] half_q;
  logic              slow_q;

  refdiv_counter u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ratio_sel_i (ratio_sel_i),
    .tc_o        (ref_tc)
  );

  assign half_en = {fb_pulse_i, ref_tc};

  // divide-by-2 monitors: index 0 reference, index 1 feedback
  for (genvar g = 0; g < N_HALF; g++) begin : g_half
    refdiv_tap #(.W(1)) u_half (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (half_en[g]),
      .q_o    (half_q[g])
    );
  end

  refdiv_tap #(.W(SLOW_W)) u_slow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ref_tc),
    .q_o    (slow_q)
  );

  always_comb begin
    case (test_sel_i[1:0])
      2'b00:   mon_o = lock_i;
      2'b01:   mon_o = half_q[0];
      2'b10:   mon_o = half_q[1];
      default: mon_o = test_sel_i[2] ? ref_tc : slow_q;
    endcase
  end

  assign ref_pulse_o = ref_tc;
  assign cp_en_o     = ~test_sel_i[2];
endmodule

// File: rtl/refdiv_mon_chk.sv
module refdiv_mon_chk
  import refdiv_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] ratio_sel_i,
  input logic [2:0] test_sel_i,
  input logic       lock_i,
  input logic       fb_pulse_i,
  input logic       ref_pulse_o,
  input logic       mon_o,
  input logic       cp_en_o
);
  localparam int GAP_W = CNT_W + 1;

  logic [GAP_W-1:0] gap_q;
  logic [GAP_W-1:0] want_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      want_q <= '0;
      seen_q <= 1'b0;
    end else if (ref_pulse_o) begin
      gap_q  <= GAP_W'(1);
      want_q <= {1'b0, ratio_of(ratio_sel_i)};
      seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q  <= gap_q + GAP_W'(1);
    end
  end

  // R1 R2
  pulse_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_pulse_o && seen_q) |-> gap_q == want_q);

  // R1 R2
  pulse_not_late_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_pulse_o && seen_q) |-> gap_q < want_q);

  // R3
  lock_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_sel_i[1:0] == 2'b00) |-> mon_o == lock_i);

  // R4
  ref_half_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_pulse_o && test_sel_i[1:0] == 2'b01) |=>
      (test_sel_i[1:0] != 2'b01 || mon_o != $past(mon_o)));

  // R4
  ref_half_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_pulse_o && test_sel_i[1:0] == 2'b01) |=>
      (test_sel_i[1:0] != 2'b01 || $stable(mon_o)));

  // R5
  fb_half_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_pulse_i && test_sel_i[1:0] == 2'b10) |=>
      (test_sel_i[1:0] != 2'b10 || mon_o != $past(mon_o)));

  // R5
  fb_half_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fb_pulse_i && test_sel_i[1:0] == 2'b10) |=>
      (test_sel_i[1:0] != 2'b10 || $stable(mon_o)));

  // R6
  slow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_pulse_o && test_sel_i == 3'b011) |=>
      (test_sel_i != 3'b011 || $stable(mon_o)));

  // R7
  raw_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_sel_i == 3'b111) |-> mon_o == ref_pulse_o);

  // R8
  cp_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_en_o != test_sel_i[2]);
endmodule

bind refdiv_mon refdiv_mon_chk i_refdiv_mon_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ratio_sel_i (ratio_sel_i),
  .test_sel_i  (test_sel_i),
  .lock_i      (lock_i),
  .fb_pulse_i  (fb_pulse_i),
  .ref_pulse_o (ref_pulse_o),
  .mon_o       (mon_o),
  .cp_en_o     (cp_en_o)
);

// File: tb/test_refdiv_mon.sv
`timescale 1ns/1ps
module test_refdiv_mon;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ratio_sel = 2'b00;
  logic [2:0] test_sel = 3'b000;
  logic       lock = 1'b0;
  logic       fb_pulse = 1'b0;
  logic       ref_pulse, mon, cp_en;
  int         n_checks = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  refdiv_mon i_refdiv_mon (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ratio_sel_i (ratio_sel),
    .test_sel_i  (test_sel),
    .lock_i      (lock),
    .fb_pulse_i  (fb_pulse),
    .ref_pulse_o (ref_pulse),
    .mon_o       (mon),
    .cp_en_o     (cp_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  // advance to the next negedge at which ref_pulse is high; n = cycles taken
  task automatic next_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      #1;
      n++;
    end while (!ref_pulse && n < 64);
  endtask

  task automatic t_reset_state();
    test_sel = 3'b001;
    do_reset();
    chk(ref_pulse == 1'b1, "R9 pulse in first cycle", int'(ref_pulse), 1);
    chk(mon == 1'b0, "R9 ref half cleared", int'(mon), 0);
    test_sel = 3'b011;
    #1;
    chk(mon == 1'b0, "R9 slow tap cleared", int'(mon), 0);
  endtask

  task automatic t_ratios();
    int n;
    for (int c = 0; c < 4; c++) begin
      int exp;
      exp = (c == 1) ? 4 : (c == 2) ? 6 : 3;
      ratio_sel = 2'(c);
      next_pulse(n);
      next_pulse(n);
      chk(n == exp, "R1 pulse spacing", n, exp);
      next_pulse(n);
      chk(n == exp, "R1 pulse spacing repeat", n, exp);
    end
  endtask

  task automatic t_mid_change();
    int n;
    ratio_sel = 2'b10;
    next_pulse(n);
    next_pulse(n);
    repeat (2) @(negedge clk);
    ratio_sel = 2'b01;
    next_pulse(n);
    chk(n == 4, "R2 running period keeps old length", n + 2, 6);
    next_pulse(n);
    chk(n == 4, "R2 new ratio after terminal count", n, 4);
  endtask

  task automatic t_lock();
    test_sel = 3'b000;
    lock = 1'b1;
    #1;
    chk(mon == 1'b1, "R3 lock high code 000", int'(mon), 1);
    chk(cp_en == 1'b1, "R8 cp active code 000", int'(cp_en), 1);
    lock = 1'b0;
    #1;
    chk(mon == 1'b0, "R3 lock low code 000", int'(mon), 0);
    test_sel = 3'b100;
    lock = 1'b1;
    #1;
    chk(mon == 1'b1, "R3 lock high code 100", int'(mon), 1);
    chk(cp_en == 1'b0, "R8 cp high-z code 100", int'(cp_en), 0);
    lock = 1'b0;
  endtask

  task automatic t_ref_half(input logic [2:0] code);
    int n;
    logic v0;
    test_sel = code;
    ratio_sel = 2'b01;
    next_pulse(n);
    next_pulse(n);
    v0 = mon;
    @(negedge clk);
    #1;
    chk(mon == ~v0, "R4 ref half toggles after pulse", int'(mon), int'(~v0));
    repeat (2) @(negedge clk);
    #1;
    chk(mon == ~v0, "R4 ref half holds between pulses", int'(mon), int'(~v0));
    next_pulse(n);
    @(negedge clk);
    #1;
    chk(mon == v0, "R4 ref half toggles back", int'(mon), int'(v0));
  endtask

  task automatic t_fb_half(input logic [2:0] code);
    logic v0;
    test_sel = code;
    @(negedge clk);
    #1;
    v0 = mon;
    fb_pulse = 1'b1;
    @(negedge clk);
    fb_pulse = 1'b0;
    #1;
    chk(mon == ~v0, "R5 fb half toggles on pulse", int'(mon), int'(~v0));
    repeat (3) @(negedge clk);
    #1;
    chk(mon == ~v0, "R5 fb half holds without pulse", int'(mon), int'(~v0));
    fb_pulse = 1'b1;
    @(negedge clk);
    fb_pulse = 1'b0;
    #1;
    chk(mon == v0, "R5 fb half toggles back", int'(mon), int'(v0));
  endtask

  task automatic t_slow();
    int k;
    int bad;
    ratio_sel = 2'b00;
    test_sel = 3'b011;
    do_reset();
    k = 0;
    bad = 0;
    chk(cp_en == 1'b1, "R8 cp active code 011", int'(cp_en), 1);
    while (k < 600) begin
      if (mon != ((k >> 8) & 1)) bad++;
      if (ref_pulse) begin
        if (k == 255) chk(mon == 1'b0, "R6 low before 256 pulses", int'(mon), 0);
        if (k == 256) chk(mon == 1'b1, "R6 high after 256 pulses", int'(mon), 1);
        if (k == 512) chk(mon == 1'b0, "R6 low after 512 pulses", int'(mon), 0);
        k++;
      end
      @(negedge clk);
      #1;
    end
    chk(bad == 0, "R6 divide-by-512 phase", bad, 0);
  endtask

  task automatic t_raw();
    int bad;
    int seen;
    bad = 0;
    seen = 0;
    test_sel = 3'b111;
    ratio_sel = 2'b01;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      #1;
      if (mon != ref_pulse) bad++;
      if (mon) seen++;
    end
    chk(bad == 0, "R7 raw pulse routed", bad, 0);
    chk(seen == 5, "R7 raw pulse count", seen, 5);
    chk(cp_en == 1'b0, "R8 cp high-z code 111", int'(cp_en), 0);
  endtask

  initial begin
    t_reset_state();
    t_ratios();
    t_mid_change();
    t_lock();
    t_ref_half(3'b001);
    t_ref_half(3'b101);
    t_fb_half(3'b010);
    t_fb_half(3'b110);
    t_slow();
    t_raw();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule